// File: doc/BRIEF.md
# Fractional Q-format multiply unit

This unit performs signed fractional multiplication for a 32-bit processor datapath. It decodes one 32-bit instruction word to pick the operand widths and the result width. It then forms the two's complement product of the source operands. Before any truncation, the product can be doubled by a one-bit left-justify amount. The result is either a 32-bit fraction taken from the product's upper part or the full 64-bit product.

An operation is presented with `in_valid`. Exactly one cycle later the registered result appears with `out_valid`, together with:
- a flag for a 64-bit-wide result;
- a flag for an undefined shift field;
- a flag for an unrecognised encoding;
- the destination index taken from the word.

Operand forms are 32x32, 32 by a sign-extended low or high halfword of the second operand, and halfword by halfword. The halfword-by-halfword form saturates the one case that would overflow.

Top module: `qmul_unit`

## Requirements
- R1: After reset `out_valid`, `out_data`, `out_wide`, `out_undef` and `out_illegal` are 0. A result is presented with `out_valid`=1 in the cycle after the `in_valid` cycle, and `out_valid` is 0 after a cycle with `in_valid`=0.
- R2: The instruction word is decoded as follows. Bits [7:0] must equal 0x93. Bits [27:18] are the form code. Bits [17:16] are the shift field n. Bits [31:28] are passed to `out_dst`. A word with another low byte, or with a form code outside the seven listed in R3 to R7, gives `out_illegal`=1, `out_data`=0 and `out_wide`=0.
- R3: Form code 0x02 returns bits [63:32] of (a*b)<<n, with both operands signed.
- R4: Form code 0x1B returns the full 64-bit value of (a*b)<<n.
- R5: Form codes 0x01 (narrow) and 0x19 (wide) use the sign-extended value of b[15:0] in place of b. The narrow result is bits [47:16] of the shifted product. The wide result is all 64 bits.
- R6: Form codes 0x00 (narrow) and 0x18 (wide) use the sign-extended value of b[31:16] in place of b. Truncation is the same as in R5.
- R7: Form code 0x05 multiplies the sign-extended a[15:0] by the sign-extended b[15:0]. It returns the low 32 bits of the product shifted left by n.
- R8: In form 0x05 with n=1, the operands a[15:0]=0x8000 and b[15:0]=0x8000 return 0x7FFFFFFF instead of the wrapped value.
- R9: An n field of 2 or 3 sets `out_undef`=1, with an unspecified result. The next operation still completes normally with `out_undef`=0.
- R10: A narrow result has `out_wide`=0 and zeroes in `out_data[63:32]`. A wide result has `out_wide`=1.
- R11: `out_data` holds its last value while `in_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Qualifies the instruction word and operands |
| instr | input | 32 | Instruction word |
| opnd_a | input | 32 | First source operand |
| opnd_b | input | 32 | Second source operand |
| out_valid | output | 1 | Result valid, one cycle after `in_valid` |
| out_wide | output | 1 | Result uses all 64 bits |
| out_undef | output | 1 | Shift field was 2 or 3 |
| out_illegal | output | 1 | Encoding not recognised |
| out_dst | output | 4 | Destination index from the word |
| out_data | output | 64 | Product result |

## Verification
The assertions assume that `in_valid`, `instr` and the operands are held stable around each rising edge, and that they are defined whenever `in_valid` is high. The saturation property also assumes that the saturating encoding uses the exact low byte and form code. The bench drives every input on the falling edge and deasserts `in_valid` between operations. It sets the undefined shift values only in a dedicated test, so those cases never reach the data comparisons.

// File: rtl/qmul_pkg.sv
package qmul_pkg;
    localparam int unsigned XW      = 32;
    localparam int unsigned HW      = XW / 2;
    localparam int unsigned PW      = 2 * XW;
    localparam int unsigned SEC_W   = 10;
    localparam int unsigned IDX_W   = 4;

    localparam logic [7:0]       PRI_OP   = 8'h93;
    localparam logic [SEC_W-1:0] SEC_F32N = 10'h02;
    localparam logic [SEC_W-1:0] SEC_F64W = 10'h1B;
    localparam logic [SEC_W-1:0] SEC_L32N = 10'h01;
    localparam logic [SEC_W-1:0] SEC_L64W = 10'h19;
    localparam logic [SEC_W-1:0] SEC_U32N = 10'h00;
    localparam logic [SEC_W-1:0] SEC_U64W = 10'h18;
    localparam logic [SEC_W-1:0] SEC_H16  = 10'h05;

    typedef enum logic [2:0] {
        FM_FULL_N, FM_FULL_W, FM_LO_N, FM_LO_W,
        FM_HI_N,   FM_HI_W,   FM_HALF, FM_NONE
    } fmode_e;

    typedef struct packed {
        fmode_e           mode;
        logic [1:0]       shamt;
        logic [IDX_W-1:0] dst;
    } dec_t;

    typedef struct packed {
        logic             vld;
        logic             wide;
        logic             undef;
        logic             illegal;
        logic [IDX_W-1:0] dst;
        logic [PW-1:0]    data;
    } res_t;
endpackage

// File: rtl/qmul_decode.sv
module qmul_decode
    import qmul_pkg::*;
(
    input  logic [XW-1:0] instr,
    output dec_t          dec
);
    logic [SEC_W-1:0] sec;

    always_comb begin
        sec       = instr[27:18];
        dec.shamt = instr[17:16];
        dec.dst   = instr[31:28];
        dec.mode  = FM_NONE;
        if (instr[7:0] == PRI_OP) begin
            unique case (sec)
                SEC_F32N: dec.mode = FM_FULL_N;
                SEC_F64W: dec.mode = FM_FULL_W;
                SEC_L32N: dec.mode = FM_LO_N;
                SEC_L64W: dec.mode = FM_LO_W;
                SEC_U32N: dec.mode = FM_HI_N;
                SEC_U64W: dec.mode = FM_HI_W;
                SEC_H16:  dec.mode = FM_HALF;
                default:  dec.mode = FM_NONE;
            endcase
        end
    end
endmodule

// File: rtl/qmul_core.sv
module qmul_core
    import qmul_pkg::*;
(
    input  fmode_e        mode,
    input  logic          shift,
    input  logic [XW-1:0] opa,
    input  logic [XW-1:0] opb,
    output logic [PW-1:0] data,
    output logic          wide
);
    localparam logic [HW-1:0] MIN_H = {1'b1, {(HW-1){1'b0}}};
    localparam logic [XW-1:0] MAX_F = {1'b0, {(XW-1){1'b1}}};

    logic signed [XW-1:0] a_s, b_s;
    logic signed [PW-1:0] prod, shf;
    logic                 sat;

    always_comb begin
        a_s = opa;
        if (mode == FM_HALF) a_s = {{HW{opa[HW-1]}}, opa[HW-1:0]};
        unique case (mode)
            FM_LO_N, FM_LO_W, FM_HALF: b_s = {{HW{opb[HW-1]}}, opb[HW-1:0]};
            FM_HI_N, FM_HI_W:          b_s = {{HW{opb[XW-1]}}, opb[XW-1:HW]};
            default:                   b_s = opb;
        endcase
        prod = a_s * b_s;
        shf  = shift ? (prod <<< 1) : prod;
        sat  = (mode == FM_HALF) && shift
               && (opa[HW-1:0] == MIN_H) && (opb[HW-1:0] == MIN_H);
        unique case (mode)
            FM_FULL_N:                   data = {{XW{1'b0}}, shf[PW-1:XW]};
            FM_FULL_W, FM_LO_W, FM_HI_W: data = shf;
            FM_LO_N, FM_HI_N:            data = {{XW{1'b0}}, shf[XW+HW-1:HW]};
            FM_HALF:                     data = {{XW{1'b0}}, sat ? MAX_F : shf[XW-1:0]};
            default:                     data = '0;
        endcase
        wide = (mode == FM_FULL_W) || (mode == FM_LO_W) || (mode == FM_HI_W);
    end
endmodule

// File: rtl/qmul_unit.sv
module qmul_unit
    import qmul_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [XW-1:0]    instr,
    input  logic [XW-1:0]    opnd_a,
    input  logic [XW-1:0]    opnd_b,
    output logic             out_valid,
    output logic             out_wide,
    output logic             out_undef,
    output logic             out_illegal,
    output logic [IDX_W-1:0] out_dst,
    output logic [PW-1:0]    out_data
);
    dec_t          dec;
    logic [PW-1:0] core_data;
    logic          core_wide;
    res_t          r_d, r_q;

    qmul_decode u_dec (.instr(instr), .dec(dec));

    qmul_core u_core (
        .mode (dec.mode),
        .shift(dec.shamt[0]),
        .opa  (opnd_a),
        .opb  (opnd_b),
        .data (core_data),
        .wide (core_wide)
    );

    always_comb begin
        r_d     = r_q;
        r_d.vld = in_valid;
        if (in_valid) begin
            r_d.wide    = core_wide;
            r_d.undef   = dec.shamt[1];
            r_d.illegal = (dec.mode == FM_NONE);
            r_d.dst     = dec.dst;
            r_d.data    = core_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign out_valid   = r_q.vld;
    assign out_wide    = r_q.wide;
    assign out_undef   = r_q.undef;
    assign out_illegal = r_q.illegal;
    assign out_dst     = r_q.dst;
    assign out_data    = r_q.data;

    a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    a_r1_idle_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    a_r2_illegal_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_illegal) |-> (out_data == '0 && !out_wide));
    a_r10_narrow_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_wide) |-> (out_data[PW-1:XW] == '0));
    a_r8_half_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && instr[7:0] == PRI_OP && instr[27:18] == SEC_H16
         && instr[17:16] == 2'b01 && opnd_a[HW-1:0] == 16'h8000
         && opnd_b[HW-1:0] == 16'h8000) |=> (out_data == 64'h7FFF_FFFF));
    a_r9_undef_flag: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (out_undef == $past(instr[17])));
    a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_data));
endmodule

// File: tb/qmul_unit_tb_top.sv
`timescale 1ns/1ps
module qmul_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] instr = '0, opnd_a = '0, opnd_b = '0;
    logic        out_valid, out_wide, out_undef, out_illegal;
    logic [3:0]  out_dst;
    logic [63:0] out_data;

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    qmul_unit dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .out_valid(out_valid),
        .out_wide(out_wide), .out_undef(out_undef), .out_illegal(out_illegal),
        .out_dst(out_dst), .out_data(out_data)
    );

    localparam int NV = 8;
    localparam logic [31:0] VA [NV] = '{32'h8000_0000, 32'h0000_8000, 32'h0000_0000,
        32'hFFFF_FFFF, 32'h8000_0000, 32'h7FFF_FFFF, 32'h1234_5678, 32'hFFFF_8000};
    localparam logic [31:0] VB [NV] = '{32'h8000_0000, 32'h0000_8000, 32'h1234_5678,
        32'hFFFF_FFFF, 32'hFFFF_8000, 32'h7FFF_8000, 32'h9ABC_DEF0, 32'h8000_8000};
    localparam int NM = 7;
    localparam logic [9:0] SECS [NM] = '{10'h02, 10'h1B, 10'h01, 10'h19, 10'h00, 10'h18, 10'h05};

    function automatic logic [31:0] mk(logic [3:0] d, logic [9:0] s, logic [1:0] n, logic [7:0] p);
        return {d, s, n, 4'h2, 4'h1, p};
    endfunction

    // reference: {wide, data}, from R3..R8 with 128-bit signed math
    function automatic logic [64:0] ref_q(logic [9:0] s, logic n, logic [31:0] a, logic [31:0] b);
        logic signed [127:0] x, y, p;
        logic [63:0] d;
        logic w;
        x = {{96{a[31]}}, a};
        y = {{96{b[31]}}, b};
        if (s == 10'h01 || s == 10'h19 || s == 10'h05) y = {{112{b[15]}}, b[15:0]};
        if (s == 10'h00 || s == 10'h18) y = {{112{b[31]}}, b[31:16]};
        if (s == 10'h05) x = {{112{a[15]}}, a[15:0]};
        p = (x * y) << n;
        w = (s == 10'h1B || s == 10'h19 || s == 10'h18);
        if (w) d = p[63:0];
        else if (s == 10'h02) d = {32'h0, p[63:32]};
        else if (s == 10'h05) d = (n && a[15:0] == 16'h8000 && b[15:0] == 16'h8000)
                                  ? 64'h7FFF_FFFF : {32'h0, p[31:0]};
        else d = {32'h0, p[47:16]};
        return {w, d};
    endfunction

    task automatic check(string req, logic [63:0] got, logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic run_op(logic [31:0] w, logic [31:0] a, logic [31:0] b);
        @(negedge clk);
        instr = w; opnd_a = a; opnd_b = b; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog got=running exp=finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 reset valid", {63'h0, out_valid}, 64'h0);
        check("R1 reset data", out_data, 64'h0);
        check("R1 reset flags", {61'h0, out_wide, out_undef, out_illegal}, 64'h0);
        @(negedge clk); rst_n = 1'b1;

        // table walk: R3 R4 R5 R6 R7 R8 R10
        for (int m = 0; m < NM; m++) begin
            for (int n = 0; n < 2; n++) begin
                for (int v = 0; v < NV; v++) begin
                    logic [64:0] e;
                    e = ref_q(SECS[m], n[0], VA[v], VB[v]);
                    run_op(mk(4'(v), SECS[m], 2'(n), 8'h93), VA[v], VB[v]);
                    check("R3-R8 data", out_data, e[63:0]);
                    check("R10 wide", {63'h0, out_wide}, {63'h0, e[64]});
                    check("R1 valid", {63'h0, out_valid}, 64'h1);
                    check("R2 dst", {60'h0, out_dst}, {60'h0, 4'(v)});
                end
            end
        end

        // R8 directed saturation
        run_op(mk(4'h3, 10'h05, 2'd1, 8'h93), 32'h1111_8000, 32'h2222_8000);
        check("R8 saturate", out_data, 64'h7FFF_FFFF);
        run_op(mk(4'h3, 10'h05, 2'd0, 8'h93), 32'h0000_8000, 32'h0000_8000);
        check("R7 no shift 8000*8000", out_data, 64'h4000_0000);

        // R11 hold while idle, R1 valid drops
        @(negedge clk); @(negedge clk);
        check("R11 hold", out_data, 64'h4000_0000);
        check("R1 idle valid", {63'h0, out_valid}, 64'h0);

        // R2 illegal encodings
        run_op(mk(4'h1, 10'h02, 2'd0, 8'h13), 32'h7, 32'h9);
        check("R2 bad primary", {62'h0, out_illegal, out_wide}, 64'h2);
        check("R2 bad primary data", out_data, 64'h0);
        run_op(mk(4'h1, 10'h3FF, 2'd0, 8'h93), 32'h7, 32'h9);
        check("R2 bad form", {62'h0, out_illegal, out_wide}, 64'h2);
        check("R2 bad form data", out_data, 64'h0);

        // R9 undefined shift, then recovery
        run_op(mk(4'h5, 10'h1B, 2'd2, 8'h93), 32'h3, 32'h5);
        check("R9 undef n=2", {63'h0, out_undef}, 64'h1);
        run_op(mk(4'h5, 10'h1B, 2'd3, 8'h93), 32'h3, 32'h5);
        check("R9 undef n=3", {63'h0, out_undef}, 64'h1);
        run_op(mk(4'h6, 10'h1B, 2'd1, 8'h93), 32'h3, 32'h5);
        check("R9 recover flag", {63'h0, out_undef}, 64'h0);
        check("R9 recover data", out_data, 64'd30);

        // R6 upper half picks b[31:16]
        run_op(mk(4'h0, 10'h18, 2'd0, 8'h93), 32'h0000_0002, 32'hFFFE_0003);
        check("R6 upper wide", out_data, 64'hFFFF_FFFF_FFFF_FFFC);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule